// File: doc/BRIEF.md
# Constant Off-Time H-Bridge Chopper Controller

This block drives the four gate signals of a single full H-bridge so that winding current is held near a threshold by chopping at a constant off-time. While the bridge conducts, one diagonal pair of switches is on. When an already-synchronized current-sense comparator bit reports that the threshold was crossed, the bridge leaves its on-time. A one-shot of programmable length then runs, and the bridge recirculates the current in the selected decay style until the one-shot expires. After that the diagonal is switched back on.

Every switch that turns on within a leg waits a dead time after its partner in the same leg turned off. After each turn-on, a blanking window masks the comparator so that a recovery spike cannot end the on-time early. In fast decay only one low-side switch is re-enabled as a rectifier, so current cannot build up in reverse. In slow decay the upper half of the bridge carries the current, with the second high side acting as a synchronous rectifier. A change of direction, or a new enable, is always preceded by an all-off gap of one dead time.

Top module: `chop_ctrl`

## Requirements
- R1: Out of reset all four gates are off. When `en` is low at a clock edge, all four gates are off after that edge and the controller returns to idle.
- R2: During on-time, `fwd` = 1 drives high-side A and low-side B (gate vector {gh_a,gl_a,gh_b,gl_b} = 1001), and `fwd` = 0 drives high-side B and low-side A (0110).
- R3: For BLANK_CYC cycles after each entry into on-time, the comparator input `trip` is ignored. A trip in the cycle after that window is accepted.
- R4: An accepted trip takes the bridge out of its on-time pattern at the clock edge that samples it.
- R5: In fast decay (`slow_decay` = 0 at the trip), all gates are off for DEAD_CYC cycles. Then only the low side of the leg whose high side had conducted is on (0100 for `fwd` = 1, 0001 for `fwd` = 0). At the end of the one-shot all gates are off for DEAD_CYC cycles before on-time resumes. The two low sides are never on together.
- R6: In slow decay (`slow_decay` = 1 at the trip), only the conducting low side turns off, and the conducting high side stays on for DEAD_CYC cycles. Then both high sides are on (1010). At the end of the one-shot the rectifying high side turns off, and the low side returns DEAD_CYC cycles later.
- R7: Counting from the first cycle after the trip edge, on-time resumes after max(`toff_len`, DEAD_CYC+1) + DEAD_CYC cycles. A `toff_len` of 0 acts as 1.
- R8: During the off-time, further trips have no effect, and a change of `slow_decay` does not alter the pattern already chosen.
- R9: A change of `fwd` during on-time turns all gates off for DEAD_CYC cycles, then the new diagonal is driven with a fresh blanking window.
- R10: When `en` rises from idle, all gates stay off for DEAD_CYC cycles before the first on-time.
- R11: The high and low gate of one leg are never on together. A gate turns on only after its leg partner has been off for at least DEAD_CYC consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Bridge enable; low forces all gates off |
| trip | input | 1 | Synchronized comparator: sensed current above reference |
| fwd | input | 1 | Diagonal select for on-time |
| slow_decay | input | 1 | Recirculation style: 0 fast, 1 slow |
| toff_len | input | TOFF_W | One-shot off-time length in cycles |
| gh_a | output | 1 | High-side gate, leg A |
| gl_a | output | 1 | Low-side gate, leg A |
| gh_b | output | 1 | High-side gate, leg B |
| gl_b | output | 1 | Low-side gate, leg B |

## Verification
The gate assertions assume that `trip`, `fwd`, `slow_decay` and `en` are synchronous to `clk` and settle between edges, and that DEAD_CYC is at least one. The stimulus changes every input only just after a falling edge, so each value is stable across the rising edge that samples it. The dead-gap counters start from the all-off reset state, which the checks rely on. The sweep keeps `toff_len` within its field and covers lengths both below and above the dead-time floor, so the recirculation stage is seen both at its single-cycle minimum and stretched.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_DRIVE,
        ST_SWAP,
        ST_OFF_GAP,
        ST_RECIRC,
        ST_BACK_GAP
    } chop_st_e;

    // bit order {hi_a, lo_a, hi_b, lo_b}
    typedef struct packed {
        logic hi_a;
        logic lo_a;
        logic hi_b;
        logic lo_b;
    } gates_t;

    localparam gates_t GATES_OFF = '0;

    function automatic gates_t drive_pattern(input logic fwd);
        gates_t g = GATES_OFF;
        if (fwd) begin
            g.hi_a = 1'b1;
            g.lo_b = 1'b1;
        end else begin
            g.hi_b = 1'b1;
            g.lo_a = 1'b1;
        end
        return g;
    endfunction

    // pattern held during either dead gap of the off-time
    function automatic gates_t gap_pattern(input logic fwd, input logic slow);
        gates_t g = GATES_OFF;
        if (slow) begin
            if (fwd) g.hi_a = 1'b1;
            else     g.hi_b = 1'b1;
        end
        return g;
    endfunction

    function automatic gates_t recirc_pattern(input logic fwd, input logic slow);
        gates_t g = GATES_OFF;
        if (slow) begin
            g.hi_a = 1'b1;
            g.hi_b = 1'b1;
        end else if (fwd) begin
            g.lo_a = 1'b1;
        end else begin
            g.lo_b = 1'b1;
        end
        return g;
    endfunction

    function automatic gates_t decode(input chop_st_e st, input logic fwd, input logic slow);
        case (st)
            ST_DRIVE:    return drive_pattern(fwd);
            ST_OFF_GAP:  return gap_pattern(fwd, slow);
            ST_RECIRC:   return recirc_pattern(fwd, slow);
            ST_BACK_GAP: return gap_pattern(fwd, slow);
            default:     return GATES_OFF;
        endcase
    endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/chop_seq.sv
module chop_seq
    import chop_pkg::*;
#(
    parameter int DEAD_CYC  = 3,
    parameter int BLANK_CYC = 4,
    parameter int PW        = 3,
    parameter int OW        = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          trip,
    input  logic          fwd,
    input  logic          slow,
    input  logic [OW-1:0] toff_len,
    input  logic          ph_zero,
    input  logic          off_zero,
    output logic          ph_load,
    output logic [PW-1:0] ph_val,
    output logic          off_load,
    output logic [OW-1:0] off_val,
    output gates_t        gates_q
);
    localparam logic [PW-1:0] DEAD_LD  = PW'(DEAD_CYC - 1);
    localparam logic [PW-1:0] BLANK_LD = PW'(BLANK_CYC);

    chop_st_e st_q, st_d;
    logic     fwd_q, fwd_d;
    logic     slow_q, slow_d;

    always_comb begin
        st_d     = st_q;
        fwd_d    = fwd_q;
        slow_d   = slow_q;
        ph_load  = 1'b0;
        ph_val   = DEAD_LD;
        off_load = 1'b0;
        off_val  = (toff_len == '0) ? '0 : toff_len - 1'b1;
        if (!en) begin
            st_d = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    st_d    = ST_ARM;
                    ph_load = 1'b1;
                end
                ST_ARM, ST_SWAP: begin
                    if (ph_zero) begin
                        st_d    = ST_DRIVE;
                        fwd_d   = fwd;
                        ph_load = 1'b1;
                        ph_val  = BLANK_LD;
                    end
                end
                ST_DRIVE: begin
                    if (fwd != fwd_q) begin
                        st_d    = ST_SWAP;
                        ph_load = 1'b1;
                    end else if (trip && ph_zero) begin
                        st_d     = ST_OFF_GAP;
                        slow_d   = slow;
                        off_load = 1'b1;
                        ph_load  = 1'b1;
                    end
                end
                ST_OFF_GAP: begin
                    if (ph_zero) st_d = ST_RECIRC;
                end
                ST_RECIRC: begin
                    if (off_zero) begin
                        st_d    = ST_BACK_GAP;
                        ph_load = 1'b1;
                    end
                end
                ST_BACK_GAP: begin
                    if (ph_zero) begin
                        st_d    = ST_DRIVE;
                        ph_load = 1'b1;
                        ph_val  = BLANK_LD;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            fwd_q   <= 1'b0;
            slow_q  <= 1'b0;
            gates_q <= GATES_OFF;
        end else begin
            st_q    <= st_d;
            fwd_q   <= fwd_d;
            slow_q  <= slow_d;
            gates_q <= decode(st_d, fwd_d, slow_d);
        end
    end

    // R8
    latched_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RECIRC && $past(st_q) == ST_RECIRC) |-> $stable(slow_q));
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int DEAD_CYC  = 3,
    parameter int BLANK_CYC = 4,
    parameter int TOFF_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              trip,
    input  logic              fwd,
    input  logic              slow_decay,
    input  logic [TOFF_W-1:0] toff_len,
    output logic              gh_a,
    output logic              gl_a,
    output logic              gh_b,
    output logic              gl_b
);
    localparam int PH_MAX = (DEAD_CYC - 1 > BLANK_CYC) ? DEAD_CYC - 1 : BLANK_CYC;
    localparam int PW     = $clog2(PH_MAX + 2);
    localparam int CW     = $clog2(DEAD_CYC + 1);

    logic              ph_load, ph_zero, off_load, off_zero;
    logic [PW-1:0]     ph_val;
    logic [TOFF_W-1:0] off_val;
    gates_t            gates;

    chop_timer #(.W(PW)) ph_tmr_i (
        .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
    );

    chop_timer #(.W(TOFF_W)) off_tmr_i (
        .clk(clk), .rst(rst), .load(off_load), .load_val(off_val), .zero(off_zero)
    );

    chop_seq #(
        .DEAD_CYC(DEAD_CYC), .BLANK_CYC(BLANK_CYC), .PW(PW), .OW(TOFF_W)
    ) seq_i (
        .clk(clk), .rst(rst), .en(en), .trip(trip), .fwd(fwd), .slow(slow_decay),
        .toff_len(toff_len), .ph_zero(ph_zero), .off_zero(off_zero),
        .ph_load(ph_load), .ph_val(ph_val), .off_load(off_load), .off_val(off_val),
        .gates_q(gates)
    );

    assign gh_a = gates.hi_a;
    assign gl_a = gates.lo_a;
    assign gh_b = gates.hi_b;
    assign gl_b = gates.lo_b;

    logic [3:0] gv;
    assign gv = {gh_a, gl_a, gh_b, gl_b};

    // R11
    no_shoot_a_chk: assert property (@(posedge clk) disable iff (rst) !(gh_a && gl_a));
    // R11
    no_shoot_b_chk: assert property (@(posedge clk) disable iff (rst) !(gh_b && gl_b));
    // R5
    no_dual_low_chk: assert property (@(posedge clk) disable iff (rst) !(gl_a && gl_b));
    // R1
    disable_off_chk: assert property (@(posedge clk) disable iff (rst) !en |=> (gv == 4'b0000));

    // off-run counter per gate; partner in the same leg is bit index ^ 1
    for (genvar i = 0; i < 4; i++) begin : g_gap
        logic [CW-1:0] offrun_q;
        always_ff @(posedge clk) begin
            if (rst)                            offrun_q <= '0;
            else if (gv[i])                     offrun_q <= '0;
            else if (offrun_q != CW'(DEAD_CYC)) offrun_q <= offrun_q + 1'b1;
        end
        // R11
        dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(gv[i ^ 1]) |-> (offrun_q == CW'(DEAD_CYC)));
    end
endmodule

// File: tb/chop_ctrl_tb.sv
module chop_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEAD  = 3;
    localparam int BLANK = 4;
    localparam int TW    = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, trip = 1'b0, fwd = 1'b0, slow = 1'b0;
    logic [TW-1:0] toff = '0;
    logic gh_a, gl_a, gh_b, gl_b;
    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    chop_ctrl #(.DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .TOFF_W(TW)) dut_i (
        .clk(clk), .rst(rst), .en(en), .trip(trip), .fwd(fwd), .slow_decay(slow),
        .toff_len(toff), .gh_a(gh_a), .gl_a(gl_a), .gh_b(gh_b), .gl_b(gl_b)
    );

    function automatic logic [3:0] on_v(input logic d);
        return d ? 4'b1001 : 4'b0110;
    endfunction
    function automatic logic [3:0] gap_v(input logic d, input logic s);
        return s ? (d ? 4'b1000 : 4'b0010) : 4'b0000;
    endfunction
    function automatic logic [3:0] rec_v(input logic d, input logic s);
        return s ? 4'b1010 : (d ? 4'b0100 : 4'b0001);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic [3:0] exp, input string tag);
        logic [3:0] got;
        got = {gh_a, gl_a, gh_b, gl_b};
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk(4'b0000, "R1 reset state");

        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 2; s++) begin
                for (int t = 0; t <= 12; t++) begin
                    int tot;
                    en = 1'b0; trip = 1'b0; fwd = d[0]; slow = s[0]; toff = TW'(t);
                    tick();
                    chk(4'b0000, "R1 disabled");
                    en = 1'b1;
                    for (int i = 0; i < DEAD; i++) begin
                        tick();
                        chk(4'b0000, "R10 enable gap");
                    end
                    tick();
                    chk(on_v(d[0]), "R2 diagonal after R10 gap");
                    trip = 1'b1;
                    for (int i = 0; i < BLANK; i++) begin
                        tick();
                        chk(on_v(d[0]), "R3 blanked trip");
                    end
                    tick();
                    tot = (t > DEAD + 1) ? t : DEAD + 1;
                    for (int k = 0; k <= tot + DEAD; k++) begin
                        logic [3:0] e;
                        if (k > 0) tick();
                        if (k < DEAD)            e = gap_v(d[0], s[0]);
                        else if (k < tot)        e = rec_v(d[0], s[0]);
                        else if (k < tot + DEAD) e = gap_v(d[0], s[0]);
                        else                     e = on_v(d[0]);
                        if (k == 0)                chk(e, "R4 off at trip edge");
                        else if (k <= 2)           chk(e, "R8 trip and mode ignored");
                        else if (k == tot + DEAD)  chk(e, "R7 off-time length");
                        else if (s != 0)           chk(e, "R6 slow decay");
                        else                       chk(e, "R5 fast decay");
                        trip = (k <= 1);
                        slow = (k == 1) ? !s[0] : s[0];
                    end
                    fwd = !d[0];
                    for (int i = 0; i < DEAD; i++) begin
                        tick();
                        chk(4'b0000, "R9 swap gap");
                    end
                    tick();
                    chk(on_v(!d[0]), "R9 new diagonal");
                end
            end
        end

        // R1 disable in the middle of a slow off-time
        en = 1'b0; trip = 1'b0; fwd = 1'b1; slow = 1'b1; toff = TW'(10);
        tick();
        en = 1'b1;
        repeat (DEAD + 1) tick();
        trip = 1'b1;
        repeat (BLANK + 1) tick();
        trip = 1'b0;
        chk(4'b1000, "R6 slow gap before disable");
        en = 1'b0;
        tick();
        chk(4'b0000, "R1 disable mid off-time");
        tick();
        chk(4'b0000, "R1 stays idle");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule